// File: doc/BRIEF.md
# Shadow-Capable Memory Map Decoder

This block turns a 16-bit CPU memory address and the bus strobes into chip enables, output and write enables, and device address lines for one 32 KB read-only boot/firmware device and one 32 KB battery-backed RAM. The top three address bits split the 64 KB space into eight 8 KB segments, and each segment is steered to one 8 KB slice of one of the two devices.

A single control bit, latched from an output port, turns on shadow mode. In this mode the RAM slice that normally sits at 32–40K also appears at 0–8K, and the boot image from the read-only device moves up to 32–40K. This lets a modified operating system run from RAM. RAM writes into the 0–8K window are blocked while shadowing is on, so stray dummy writes cannot corrupt the shadow copy. Refresh cycles that fetch display patterns from 0–8K still read the read-only device, so the character set survives the swap.

Top module: `shmap_decoder`

## Requirements
- R1: With shadow off, segments 0, 5, 6, 7 (A15..A13) select the read-only device slices 0, 1, 2, 3, and segments 1, 2, 3, 4 select RAM slices 0, 1, 2, 3. The slice number is driven on dev_addr[14:13].
- R2: With shadow on, segment 0 selects RAM slice 3 and segment 4 selects read-only slice 0. All other segments map as in R1.
- R3: With shadow on, a write to segment 0 keeps ram_we_n high. Writes to other RAM segments still drive ram_we_n low.
- R4: A refresh cycle (mreq_n and rfsh_n both low) in segment 0 selects read-only slice 0 in either mode.
- R5: No chip enable is low while mreq_n is high, and never are both chip enables low at once.
- R6: Shadow mode is off after reset. On a clock edge with ctl_we high, the mode takes the value of ctl_d. With ctl_we low, the mode holds.
- R7: dev_addr[12:0] always equals addr[12:0].
- R8: mem_oe_n is low exactly when mreq_n is low and either rd_n or rfsh_n is low. ram_we_n is low only when RAM is selected, wr_n is low, rfsh_n is high and the write is not blocked. The read-only device has no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the shadow control bit |
| rst_n | input | 1 | Active-low reset; clears shadow mode |
| ctl_we | input | 1 | Port write strobe for the shadow control bit |
| ctl_d | input | 1 | Shadow control value (port data bit 7) |
| addr | input | 16 | CPU address |
| mreq_n | input | 1 | Active-low memory request |
| rfsh_n | input | 1 | Active-low refresh cycle indicator |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ram_ce_n | output | 1 | Active-low RAM chip enable |
| rom_ce_n | output | 1 | Active-low read-only device chip enable |
| mem_oe_n | output | 1 | Active-low output enable shared by both devices |
| ram_we_n | output | 1 | Active-low RAM write enable |
| dev_addr | output | 15 | Device address: slice on [14:13], offset on [12:0] |

## Verification
The bench checks the two swapped segments in both modes. A decoder that swaps only one direction would leave either 0–8K or 32–40K on the wrong device or slice. It drives writes into the shadowed window, where a missing write block would pull ram_we_n low. It also drives refresh fetches at 0–8K with shadow on, where a decoder that ignores refresh would hand pattern fetches to RAM slice 3. Writes to the control bit with the data low, and a reset during shadow mode, show whether the mode register captures, holds and clears as required.

// File: rtl/shmap_pkg.sv
package shmap_pkg;
   typedef enum logic {
      DEV_ROM = 1'b0,
      DEV_RAM = 1'b1
   } mem_dev_e;

   localparam int DEF_ADDR_W     = 16;
   localparam int DEF_SEG_W      = 3;
   localparam int DEF_DEV_ADDR_W = 15;
endpackage

// File: rtl/shmap_ctl_reg.sv
module shmap_ctl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_we,
   input  logic ctl_d,
   output logic shadow_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow_en <= 1'b0;
      else if (ctl_we) shadow_en <= ctl_d;
   end

   // R6: write strobe captures, no strobe holds
   assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (shadow_en == $past(ctl_d)));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> $stable(shadow_en));
endmodule

// File: rtl/shmap_seg_route.sv
module shmap_seg_route
   import shmap_pkg::*;
#(
   parameter int SEG_W         = DEF_SEG_W,
   parameter int SLICE_W       = 2,
   parameter int RAM_FIRST_SEG = 1,
   parameter int RAM_SEGS      = 4,
   parameter int BOOT_SEG      = 0,
   parameter int SWAP_SEG      = 4
) (
   input  logic [SEG_W-1:0]   seg,
   input  logic               shadow_en,
   input  logic               refresh,
   output mem_dev_e           dev,
   output logic [SLICE_W-1:0] slice,
   output logic               wprot
);
   localparam int NSEG      = 1 << SEG_W;
   localparam int BOOT_SL   = (BOOT_SEG < RAM_FIRST_SEG) ? BOOT_SEG : BOOT_SEG - RAM_SEGS;
   localparam int SWAP_RSL  = SWAP_SEG - RAM_FIRST_SEG;

   if (RAM_FIRST_SEG + RAM_SEGS > NSEG) begin : g_bad_ram
      $error("RAM segments exceed address space");
   end
   if (SWAP_SEG < RAM_FIRST_SEG || SWAP_SEG >= RAM_FIRST_SEG + RAM_SEGS) begin : g_bad_swap
      $error("swap segment must be a RAM segment");
   end
   if (BOOT_SEG >= RAM_FIRST_SEG && BOOT_SEG < RAM_FIRST_SEG + RAM_SEGS) begin : g_bad_boot
      $error("boot segment must be a read-only segment");
   end

   logic [NSEG-1:0]    nrm_ram;
   logic [NSEG-1:0]    shd_ram;
   logic [SLICE_W-1:0] nrm_sl [NSEG];
   logic [SLICE_W-1:0] shd_sl [NSEG];

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam bit IS_RAM = (s >= RAM_FIRST_SEG) && (s < RAM_FIRST_SEG + RAM_SEGS);
      localparam int SL     = IS_RAM ? (s - RAM_FIRST_SEG)
                                     : ((s < RAM_FIRST_SEG) ? s : (s - RAM_SEGS));
      assign nrm_ram[s] = IS_RAM;
      assign nrm_sl[s]  = SLICE_W'(SL);
      if (s == BOOT_SEG) begin : g_boot
         assign shd_ram[s] = 1'b1;
         assign shd_sl[s]  = SLICE_W'(SWAP_RSL);
      end else if (s == SWAP_SEG) begin : g_swap
         assign shd_ram[s] = 1'b0;
         assign shd_sl[s]  = SLICE_W'(BOOT_SL);
      end else begin : g_same
         assign shd_ram[s] = IS_RAM;
         assign shd_sl[s]  = SLICE_W'(SL);
      end
   end

   logic in_boot;
   assign in_boot = (seg == SEG_W'(BOOT_SEG));

   always_comb begin
      if (refresh && in_boot) begin
         dev   = DEV_ROM;
         slice = SLICE_W'(BOOT_SL);
      end else if (shadow_en) begin
         dev   = shd_ram[seg] ? DEV_RAM : DEV_ROM;
         slice = shd_sl[seg];
      end else begin
         dev   = nrm_ram[seg] ? DEV_RAM : DEV_ROM;
         slice = nrm_sl[seg];
      end
      wprot = shadow_en && in_boot && !refresh;
   end
endmodule

// File: rtl/shmap_strobes.sv
module shmap_strobes
   import shmap_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     mreq_n,
   input  logic     rfsh_n,
   input  logic     rd_n,
   input  logic     wr_n,
   input  mem_dev_e dev,
   input  logic     wprot,
   output logic     ram_ce_n,
   output logic     rom_ce_n,
   output logic     mem_oe_n,
   output logic     ram_we_n
);
   logic req;
   assign req      = !mreq_n;
   assign ram_ce_n = !(req && dev == DEV_RAM);
   assign rom_ce_n = !(req && dev == DEV_ROM);
   assign mem_oe_n = !(req && (!rd_n || !rfsh_n));
   assign ram_we_n = !(req && dev == DEV_RAM && !wr_n && rfsh_n && !wprot);

   // R5: enables need a memory request and never overlap
   assert_ce_needs_mreq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_n |-> (ram_ce_n && rom_ce_n));
   assert_ce_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!ram_ce_n, !rom_ce_n}) <= 1);
   // R3: blocked window never writes
   assert_wprot_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wprot |-> ram_we_n);
   // R8: write strobe only with RAM enabled and outside refresh
   assert_we_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (!ram_ce_n && !wr_n && rfsh_n));
endmodule

// File: rtl/shmap_decoder.sv
module shmap_decoder
   import shmap_pkg::*;
#(
   parameter int ADDR_W        = DEF_ADDR_W,
   parameter int SEG_W         = DEF_SEG_W,
   parameter int DEV_ADDR_W    = DEF_DEV_ADDR_W,
   parameter int RAM_FIRST_SEG = 1,
   parameter int RAM_SEGS      = 4,
   parameter int BOOT_SEG      = 0,
   parameter int SWAP_SEG      = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_we,
   input  logic                  ctl_d,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  mreq_n,
   input  logic                  rfsh_n,
   input  logic                  rd_n,
   input  logic                  wr_n,
   output logic                  ram_ce_n,
   output logic                  rom_ce_n,
   output logic                  mem_oe_n,
   output logic                  ram_we_n,
   output logic [DEV_ADDR_W-1:0] dev_addr
);
   localparam int OFS_W   = ADDR_W - SEG_W;
   localparam int SLICE_W = DEV_ADDR_W - OFS_W;

   if (SLICE_W < 1) begin : g_bad_width
      $error("device address must be wider than the segment offset");
   end

   logic               shadow_en;
   mem_dev_e           dev;
   logic [SLICE_W-1:0] slice;
   logic               wprot;
   logic [SEG_W-1:0]   seg;

   assign seg = addr[ADDR_W-1 -: SEG_W];

   shmap_ctl_reg u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_d     (ctl_d),
      .shadow_en (shadow_en)
   );

   shmap_seg_route #(
      .SEG_W         (SEG_W),
      .SLICE_W       (SLICE_W),
      .RAM_FIRST_SEG (RAM_FIRST_SEG),
      .RAM_SEGS      (RAM_SEGS),
      .BOOT_SEG      (BOOT_SEG),
      .SWAP_SEG      (SWAP_SEG)
   ) u_route (
      .seg       (seg),
      .shadow_en (shadow_en),
      .refresh   (!rfsh_n),
      .dev       (dev),
      .slice     (slice),
      .wprot     (wprot)
   );

   shmap_strobes u_strb (
      .clk      (clk),
      .rst_n    (rst_n),
      .mreq_n   (mreq_n),
      .rfsh_n   (rfsh_n),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .dev      (dev),
      .wprot    (wprot),
      .ram_ce_n (ram_ce_n),
      .rom_ce_n (rom_ce_n),
      .mem_oe_n (mem_oe_n),
      .ram_we_n (ram_we_n)
   );

   assign dev_addr = {slice, addr[OFS_W-1:0]};

   // R7: offset passes straight through
   assert_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_addr[OFS_W-1:0] == addr[OFS_W-1:0]);
   // R4: refresh in the boot segment reaches the read-only device
   assert_refresh_rom_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && !rfsh_n && seg == SEG_W'(BOOT_SEG)) |-> (!rom_ce_n && ram_ce_n));
   // R2: shadowed boot read lands in RAM
   assert_shadow_boot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_en && !mreq_n && rfsh_n && seg == SEG_W'(BOOT_SEG)) |->
      (!ram_ce_n && dev_addr[DEV_ADDR_W-1:OFS_W] == SLICE_W'(SWAP_SEG - RAM_FIRST_SEG)));
   // R1: no shadow, boot segment on the read-only device
   assert_normal_boot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!shadow_en && !mreq_n && seg == SEG_W'(BOOT_SEG)) |-> !rom_ce_n);
endmodule

// File: tb/shmap_decoder_tb_top.sv
module shmap_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic        ctl_d = 1'b0;
   logic [15:0] addr = 16'h0;
   logic        mreq_n = 1'b1, rfsh_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic        ram_ce_n, rom_ce_n, mem_oe_n, ram_we_n;
   logic [14:0] dev_addr;

   int checks = 0;
   int fails  = 0;
   logic cur_sh = 1'b0;

   always #10 clk = ~clk;

   shmap_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_d(ctl_d),
      .addr(addr), .mreq_n(mreq_n), .rfsh_n(rfsh_n), .rd_n(rd_n), .wr_n(wr_n),
      .ram_ce_n(ram_ce_n), .rom_ce_n(rom_ce_n), .mem_oe_n(mem_oe_n),
      .ram_we_n(ram_we_n), .dev_addr(dev_addr)
   );

   // fields: shadow, addr, {mreq_n,rfsh_n,rd_n,wr_n}, {ram_ce_n,rom_ce_n,oe_n,we_n}, slice
   localparam int NV = 17;
   localparam logic [26:0] VEC [0:NV-1] = '{
      {1'b0, 16'h0123, 4'b0101, 4'b1001, 2'd0},  // R1 boot read
      {1'b0, 16'h2000, 4'b0101, 4'b0101, 2'd0},  // R1 RAM slice 0
      {1'b0, 16'h5FFF, 4'b0110, 4'b0110, 2'd1},  // R8 RAM write
      {1'b0, 16'h9000, 4'b0101, 4'b0101, 2'd3},  // R1 RAM slice 3
      {1'b0, 16'hA000, 4'b0101, 4'b1001, 2'd1},  // R1 ROM slice 1
      {1'b0, 16'hFFFF, 4'b0101, 4'b1001, 2'd3},  // R1 ROM slice 3
      {1'b0, 16'h1000, 4'b0110, 4'b1011, 2'd0},  // R8 ROM write no strobe
      {1'b0, 16'h1E08, 4'b0011, 4'b1001, 2'd0},  // R4 refresh normal
      {1'b0, 16'h2000, 4'b1111, 4'b1111, 2'd0},  // R5 idle
      {1'b0, 16'h2100, 4'b0011, 4'b0101, 2'd0},  // R8 refresh to RAM
      {1'b1, 16'h0100, 4'b0101, 4'b0101, 2'd3},  // R2 shadow boot read
      {1'b1, 16'h0004, 4'b0110, 4'b0111, 2'd3},  // R3 blocked write
      {1'b1, 16'h8000, 4'b0101, 4'b1001, 2'd0},  // R2 boot image moved
      {1'b1, 16'h1E00, 4'b0011, 4'b1001, 2'd0},  // R4 refresh shadow
      {1'b1, 16'h8100, 4'b0110, 4'b1011, 2'd0},  // R2 write to moved image
      {1'b1, 16'h3000, 4'b0110, 4'b0110, 2'd0},  // R3 other RAM writable
      {1'b1, 16'hC000, 4'b0101, 4'b1001, 2'd2}   // R2 unchanged segment
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_d = v;
      @(negedge clk);
      ctl_we = 1'b0; ctl_d = 1'b0;
      cur_sh = v;
   endtask

   task automatic bus(input logic [15:0] a, input logic [3:0] s);
      @(negedge clk);
      addr = a;
      {mreq_n, rfsh_n, rd_n, wr_n} = s;
      #5;
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6 reset state: boot segment on read-only device
      bus(16'h0000, 4'b0101);
      check("R6 reset rom_ce_n", {31'd0, rom_ce_n}, 32'd0);
      check("R6 reset ram_ce_n", {31'd0, ram_ce_n}, 32'd1);

      for (int i = 0; i < NV; i++) begin
         logic        sh;
         logic [15:0] a;
         logic [3:0]  s, e;
         logic [1:0]  sl;
         {sh, a, s, e, sl} = VEC[i];
         if (sh != cur_sh) set_mode(sh);
         bus(a, s);
         check($sformatf("R1/R2 vec%0d strobes", i),
               {28'd0, ram_ce_n, rom_ce_n, mem_oe_n, ram_we_n}, {28'd0, e});
         check($sformatf("R1/R2 vec%0d slice", i), {30'd0, dev_addr[14:13]}, {30'd0, sl});
         check($sformatf("R7 vec%0d offset", i), {19'd0, dev_addr[12:0]}, {19'd0, a[12:0]});
         check($sformatf("R5 vec%0d exclusive", i), {31'd0, !ram_ce_n && !rom_ce_n}, 32'd0);
      end

      // R6 hold: no strobe keeps shadow on across cycles
      bus(16'h0000, 4'b1111);
      ctl_d = 1'b0;
      repeat (3) @(negedge clk);
      bus(16'h0010, 4'b0101);
      check("R6 hold", {31'd0, ram_ce_n}, 32'd0);

      // R6 write with data low turns shadow off
      set_mode(1'b0);
      bus(16'h0010, 4'b0101);
      check("R6 clear rom_ce_n", {31'd0, rom_ce_n}, 32'd0);
      bus(16'h0004, 4'b0110);
      check("R3 normal boot write no RAM strobe", {31'd0, ram_we_n}, 32'd1);

      // R6 reset in shadow mode restores normal map
      set_mode(1'b1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      cur_sh = 1'b0;
      bus(16'h8000, 4'b0101);
      check("R6 reset clears shadow", {30'd0, ram_ce_n, rom_ce_n}, 32'd1);
      check("R6 reset slice", {30'd0, dev_addr[14:13]}, 32'd3);

      // R5 no enable without request, even in shadow with refresh
      set_mode(1'b1);
      bus(16'h0000, 4'b1011);
      check("R5 no mreq", {30'd0, ram_ce_n, rom_ce_n}, 32'd3);
      check("R8 oe idle", {31'd0, mem_oe_n}, 32'd1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule